// File: doc/BRIEF.md
# Ladder Instruction Step Evaluator

This block executes a single relay-ladder instruction on each clock cycle in which a step strobe is high. The caller provides an opcode, a slot address, a vector of up to sixteen input bits and a count that says how many of those bits are in use. Every slot in a small internal register file holds two bits for one instruction in the ladder program. The first is the slot's output bit. The second is a memory bit that the edge-detecting instructions use. The block reads the slot and computes the new output bit. When the instruction detects edges, it also computes a new memory bit. It writes both back to the slot and presents them on registered result ports one cycle later.

The supported instructions are contacts, negation, list operations and coils. The contacts are open-when-idle and closed-when-idle, and negation inverts a bit. The list operations are AND, OR and parity over the active bits. The coils are plain, inverted, set and clear. There are two latches: one where set wins and one where reset wins. There are rising and falling edge pulses, which compare the input against the slot's memory bit and then store the input there. The block raises an error when it sees an unknown opcode or a parity list with fewer than two bits. In that case it leaves the slot untouched.

A sequencer walks through a ladder program one instruction at a time, one slot per instruction. It reads each result bit and feeds it into the following instructions.

Top module: `ladder_eval`

## Requirements
- R1: After reset, res_valid, res_out, res_mem and res_err are 0, and every slot holds output 0 and memory 0.
- R2: A step presented with step_valid high in one cycle yields res_valid high in the next cycle and only then. Back-to-back steps to the same slot see each other's writes. While no step is presented, res_out, res_mem and res_err hold their values.
- R3: Opcode 0 (contact, open at rest) and opcode 6 (drive coil) produce step_bits[0]. Opcodes 1 (contact, closed at rest), 2 (invert) and 7 (inverted drive coil) produce the inverse of step_bits[0].
- R4: Opcode 3 gives 1 exactly when all bits step_bits[n-1:0] are 1. Opcode 4 gives 1 exactly when any of those bits is 1. Here n is step_len limited to 16. With n = 0, opcode 3 gives 1 and opcode 4 gives 0. Bits at position n and above have no effect.
- R5: Opcode 5 gives the XOR of step_bits[n-1:0]. With n below 2 it is an error.
- R6: Opcode 8 sets the slot output to 1 when step_bits[0] is 1. Opcode 9 clears it to 0 when step_bits[0] is 1. Otherwise both keep the previous slot output.
- R7: Opcode 10 is a latch with set in step_bits[0] and reset in step_bits[1]. Set wins, so the output is 1 whenever set is 1. It is 0 when only reset is 1 and holds when both are 0.
- R8: Opcode 11 uses the same inputs as R7, but reset wins. The output is 0 whenever reset is 1. It is 1 when only set is 1 and holds when both are 0.
- R9: Opcode 12 outputs 1 only when the slot memory bit is 0 and step_bits[0] is 1. It then stores step_bits[0] as the new memory bit.
- R10: Opcode 13 outputs 1 only when the slot memory bit is 1 and step_bits[0] is 0. It then stores step_bits[0]. Opcodes other than 12 and 13 leave the memory bit unchanged.
- R11: Opcodes 14 and 15, and the case in R5 with n below 2, raise res_err. In these cases the slot's output and memory stay unchanged, and res_out and res_mem report those kept values.
- R12: Each slot's state is independent. A step changes only the slot at step_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_valid | input | 1 | Evaluate one instruction this cycle |
| step_op | input | 4 | Instruction opcode |
| step_addr | input | ADDR_W (4) | Slot holding the instruction's output and memory bits |
| step_bits | input | IN_W (16) | Instruction input bits |
| step_len | input | LEN_W (5) | Number of active bits for list instructions |
| res_valid | output | 1 | Result of the previous cycle's step is present |
| res_out | output | 1 | New output bit of the slot |
| res_mem | output | 1 | Memory bit of the slot after the step |
| res_err | output | 1 | The step was rejected |

## Verification
The list instructions are tested with all-ones, mixed and zero-length inputs, and with garbage in the bits above the active length. These cases show whether the length mask is applied and whether the empty-list identities are right. The latches are driven through all four set/reset combinations, so the set-wins latch is told apart from the reset-wins latch, and the hold case is told apart from both. The edge pulses get input sequences of 0,1,1,0 and 1,0,0,1, which separate a single-cycle pulse from a level. Error steps are placed between writes to the same slot, and neighbouring slots are read back, to show that rejected steps and steps to other slots leave stored state alone.

// File: rtl/ladder_pkg.sv
package ladder_pkg;

  typedef enum logic [3:0] {
    OP_CONTACT      = 4'd0,
    OP_CONTACT_INV  = 4'd1,
    OP_INVERT       = 4'd2,
    OP_ALL          = 4'd3,
    OP_ANY          = 4'd4,
    OP_PARITY       = 4'd5,
    OP_DRIVE        = 4'd6,
    OP_DRIVE_INV    = 4'd7,
    OP_SET          = 4'd8,
    OP_CLEAR        = 4'd9,
    OP_LATCH_SETWIN = 4'd10,
    OP_LATCH_CLRWIN = 4'd11,
    OP_PULSE_UP     = 4'd12,
    OP_PULSE_DOWN   = 4'd13
  } op_e;

  // set has priority over reset
  function automatic logic latch_setwin(input logic s, input logic r, input logic q);
    return s | (q & ~r);
  endfunction

  // reset has priority over set
  function automatic logic latch_clrwin(input logic s, input logic r, input logic q);
    return ~r & (s | q);
  endfunction

  function automatic logic pulse_up(input logic d, input logic prev);
    return d & ~prev;
  endfunction

  function automatic logic pulse_down(input logic d, input logic prev);
    return ~d & prev;
  endfunction

endpackage

// File: rtl/ladder_decode.sv
module ladder_decode
  import ladder_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic [3:0]       op,
  input  logic [LEN_W-1:0] len,
  output logic             op_known,
  output logic             list_short,
  output logic             err
);

  localparam logic [3:0] LAST_OP = 4'(OP_PULSE_DOWN);

  assign op_known   = (op <= LAST_OP);
  assign list_short = (op == 4'(OP_PARITY)) && (len < LEN_W'(2));
  assign err        = ~op_known | list_short;

endmodule

// File: rtl/ladder_alu.sv
module ladder_alu
  import ladder_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int LEN_W = 5
) (
  input  logic [3:0]       op,
  input  logic [IN_W-1:0]  bits,
  input  logic [LEN_W-1:0] len,
  input  logic             cur_out,
  input  logic             cur_mem,
  output logic             nxt_out,
  output logic             nxt_mem
);

  logic [IN_W-1:0] active;

  generate
    for (genvar i = 0; i < IN_W; i++) begin : g_mask
      assign active[i] = (len > LEN_W'(i));
    end
  endgenerate

  logic all_set, any_set, parity;
  assign all_set = &(bits | ~active);
  assign any_set = |(bits & active);
  assign parity  = ^(bits & active);

  logic d0, d1;
  assign d0 = bits[0];
  assign d1 = bits[1];

  always_comb begin
    nxt_out = cur_out;
    nxt_mem = cur_mem;
    case (op)
      OP_CONTACT:      nxt_out = d0;
      OP_CONTACT_INV:  nxt_out = ~d0;
      OP_INVERT:       nxt_out = ~d0;
      OP_ALL:          nxt_out = all_set;
      OP_ANY:          nxt_out = any_set;
      OP_PARITY:       nxt_out = parity;
      OP_DRIVE:        nxt_out = d0;
      OP_DRIVE_INV:    nxt_out = ~d0;
      OP_SET:          nxt_out = d0 | cur_out;
      OP_CLEAR:        nxt_out = ~d0 & cur_out;
      OP_LATCH_SETWIN: nxt_out = latch_setwin(d0, d1, cur_out);
      OP_LATCH_CLRWIN: nxt_out = latch_clrwin(d0, d1, cur_out);
      OP_PULSE_UP: begin
        nxt_out = pulse_up(d0, cur_mem);
        nxt_mem = d0;
      end
      OP_PULSE_DOWN: begin
        nxt_out = pulse_down(d0, cur_mem);
        nxt_mem = d0;
      end
      default: begin
        nxt_out = cur_out;
        nxt_mem = cur_mem;
      end
    endcase
  end

endmodule

// File: rtl/ladder_slots.sv
module ladder_slots #(
  parameter int SLOTS  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_out,
  input  logic              wr_mem,
  output logic              rd_out,
  output logic              rd_mem
);

  logic [SLOTS-1:0] out_q;
  logic [SLOTS-1:0] mem_q;

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          out_q[s] <= 1'b0;
          mem_q[s] <= 1'b0;
        end else if (wr_en && (addr == ADDR_W'(s))) begin
          out_q[s] <= wr_out;
          mem_q[s] <= wr_mem;
        end
      end
    end
  endgenerate

  assign rd_out = out_q[addr];
  assign rd_mem = mem_q[addr];

endmodule

// File: rtl/ladder_eval.sv
module ladder_eval
  import ladder_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int SLOTS = 16,
  parameter int ADDR_W = $clog2(SLOTS),
  parameter int LEN_W  = $clog2(IN_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_valid,
  input  logic [3:0]        step_op,
  input  logic [ADDR_W-1:0] step_addr,
  input  logic [IN_W-1:0]   step_bits,
  input  logic [LEN_W-1:0]  step_len,
  output logic              res_valid,
  output logic              res_out,
  output logic              res_mem,
  output logic              res_err
);

  // named internal events used by the bound checker
  logic cur_out, cur_mem;
  logic nxt_out, nxt_mem;
  logic op_known, list_short, err_now;
  logic commit;

  ladder_decode #(.LEN_W(LEN_W)) u_dec (
    .op(step_op), .len(step_len),
    .op_known(op_known), .list_short(list_short), .err(err_now)
  );

  ladder_alu #(.IN_W(IN_W), .LEN_W(LEN_W)) u_alu (
    .op(step_op), .bits(step_bits), .len(step_len),
    .cur_out(cur_out), .cur_mem(cur_mem),
    .nxt_out(nxt_out), .nxt_mem(nxt_mem)
  );

  assign commit = step_valid & ~err_now;

  ladder_slots #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .wr_en(commit), .addr(step_addr),
    .wr_out(nxt_out), .wr_mem(nxt_mem),
    .rd_out(cur_out), .rd_mem(cur_mem)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_out   <= 1'b0;
      res_mem   <= 1'b0;
      res_err   <= 1'b0;
    end else begin
      res_valid <= step_valid;
      if (step_valid) begin
        res_err <= err_now;
        res_out <= err_now ? cur_out : nxt_out;
        res_mem <= err_now ? cur_mem : nxt_mem;
      end
    end
  end

endmodule

// File: rtl/ladder_eval_chk.sv
module ladder_eval_chk #(
  parameter int IN_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            step_valid,
  input logic [3:0]      step_op,
  input logic [IN_W-1:0] step_bits,
  input logic            cur_out,
  input logic            cur_mem,
  input logic            err_now,
  input logic            res_valid,
  input logic            res_out,
  input logic            res_mem,
  input logic            res_err
);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (res_valid == $past(step_valid)));

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !step_valid |=> ($stable(res_out) && $stable(res_mem) && $stable(res_err)));

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && step_op == 4'd10 && step_bits[0]) |=> res_out);

  a_r8_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && step_op == 4'd11 && step_bits[1]) |=> !res_out);

  a_r9_up_memory: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && step_op == 4'd12) |=> (res_mem == $past(step_bits[0])));

  a_r9_up_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && step_op == 4'd12 && cur_mem) |=> !res_out);

  a_r10_down_memory: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && step_op == 4'd13) |=> (res_mem == $past(step_bits[0])));

  a_r11_bad_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && step_op >= 4'd14) |=> res_err);

  a_r11_err_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && err_now) |=> (res_out == $past(cur_out) && res_mem == $past(cur_mem)));

endmodule

bind ladder_eval ladder_eval_chk #(.IN_W(IN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_op(step_op),
  .step_bits(step_bits), .cur_out(cur_out), .cur_mem(cur_mem),
  .err_now(err_now), .res_valid(res_valid), .res_out(res_out),
  .res_mem(res_mem), .res_err(res_err)
);

// File: tb/tb_ladder_eval.sv
module tb_ladder_eval;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W = 16;
  localparam int SLOTS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_valid = 1'b0;
  logic [3:0]  step_op = '0;
  logic [3:0]  step_addr = '0;
  logic [15:0] step_bits = '0;
  logic [4:0]  step_len = '0;
  logic        res_valid, res_out, res_mem, res_err;

  ladder_eval dut (
    .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_op(step_op),
    .step_addr(step_addr), .step_bits(step_bits), .step_len(step_len),
    .res_valid(res_valid), .res_out(res_out), .res_mem(res_mem), .res_err(res_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  bit m_out[SLOTS];
  bit m_mem[SLOTS];
  bit e_out, e_mem, e_err;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired: cycles=%0d expected below 100000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input bit v, input bit o, input bit m, input bit e);
    tests++;
    if (res_valid !== v || res_out !== o || res_mem !== m || res_err !== e) begin
      fails++;
      $display("FAIL %s: got valid=%b out=%b mem=%b err=%b, expected valid=%b out=%b mem=%b err=%b",
               tag, res_valid, res_out, res_mem, res_err, v, o, m, e);
    end
  endtask

  // behavioural reference for one step
  task automatic model(input int op, input int a, input logic [15:0] b, input int len);
    int n = (len > IN_W) ? IN_W : len;
    int ones = 0;
    bit q = m_out[a];
    bit pm = m_mem[a];
    bit o = q;
    bit nm = pm;
    bit bad = 0;
    for (int i = 0; i < n; i++) if (b[i]) ones++;
    case (op)
      0, 6:    o = b[0];
      1, 2, 7: o = !b[0];
      3:       o = (ones == n);
      4:       o = (ones != 0);
      5:       if (n < 2) bad = 1; else o = (ones % 2) == 1;
      8:       o = b[0] ? 1'b1 : q;
      9:       o = b[0] ? 1'b0 : q;
      10:      o = b[0] ? 1'b1 : (b[1] ? 1'b0 : q);
      11:      o = b[1] ? 1'b0 : (b[0] ? 1'b1 : q);
      12:      begin o = b[0] && !pm; nm = b[0]; end
      13:      begin o = !b[0] && pm; nm = b[0]; end
      default: bad = 1;
    endcase
    if (bad) begin
      e_out = q; e_mem = pm; e_err = 1;
    end else begin
      m_out[a] = o; m_mem[a] = nm;
      e_out = o; e_mem = nm; e_err = 0;
    end
  endtask

  // drive at a falling edge, compare at the next falling edge
  task automatic step(input string tag, input int op, input int a, input logic [15:0] b, input int len);
    step_valid = 1'b1;
    step_op    = 4'(op);
    step_addr  = 4'(a);
    step_bits  = b;
    step_len   = 5'(len);
    model(op, a, b, len);
    @(negedge clk);
    step_valid = 1'b0;
    check(tag, 1'b1, e_out, e_mem, e_err);
  endtask

  task automatic idle(input string tag);
    step_bits = 16'hFFFF;
    step_op   = 4'd8;
    @(negedge clk);
    check(tag, 1'b0, e_out, e_mem, e_err);
  endtask

  initial begin
    for (int s = 0; s < SLOTS; s++) begin m_out[s] = 0; m_mem[s] = 0; end
    e_out = 0; e_mem = 0; e_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset outputs", 1'b0, 1'b0, 1'b0, 1'b0);

    // R1: untouched slots read as zero via hold-type coils
    step("R1 slot zero out", 8, 7, 16'h0000, 0);
    step("R1 slot zero mem", 13, 9, 16'h0000, 0);

    // R3
    step("R3 contact 1", 0, 0, 16'h0001, 0);
    step("R3 contact 0", 0, 0, 16'hFFFE, 0);
    step("R3 contact inv", 1, 1, 16'h0000, 0);
    step("R3 invert", 2, 1, 16'h0001, 0);
    step("R3 drive", 6, 2, 16'h0001, 0);
    step("R3 drive inv", 7, 2, 16'h0001, 0);

    // R4
    step("R4 all ones", 3, 3, 16'h0007, 3);
    step("R4 all mixed", 3, 3, 16'h0005, 3);
    step("R4 all empty", 3, 3, 16'h0000, 0);
    step("R4 all masked", 3, 3, 16'hFFF0, 4);
    step("R4 any masked", 4, 3, 16'hFFF0, 4);
    step("R4 any one", 4, 3, 16'h0008, 4);
    step("R4 any empty", 4, 3, 16'hFFFF, 0);
    step("R4 all len over", 3, 3, 16'hFFFF, 20);
    step("R4 any len over", 4, 3, 16'h8000, 31);

    // R5
    step("R5 parity even", 5, 4, 16'h0003, 3);
    step("R5 parity odd", 5, 4, 16'h0007, 3);
    step("R5 parity masked", 5, 4, 16'hFF01, 8);
    step("R5 parity short err", 5, 4, 16'h0001, 1);
    step("R5 parity zero err", 5, 4, 16'h0001, 0);

    // R6
    step("R6 set", 8, 5, 16'h0001, 0);
    step("R6 set hold", 8, 5, 16'h0000, 0);
    step("R6 clear hold", 9, 5, 16'h0000, 0);
    step("R6 clear", 9, 5, 16'h0001, 0);
    step("R6 clear hold low", 9, 5, 16'h0000, 0);

    // R7
    step("R7 set only", 10, 6, 16'h0001, 0);
    step("R7 hold", 10, 6, 16'h0000, 0);
    step("R7 reset only", 10, 6, 16'h0002, 0);
    step("R7 both", 10, 6, 16'h0003, 0);
    step("R7 hold high", 10, 6, 16'h0000, 0);

    // R8
    step("R8 both", 11, 8, 16'h0003, 0);
    step("R8 set only", 11, 8, 16'h0001, 0);
    step("R8 hold", 11, 8, 16'h0000, 0);
    step("R8 both clears", 11, 8, 16'h0003, 0);
    step("R8 reset only", 11, 8, 16'h0002, 0);

    // R9: sequence 0,1,1,0
    step("R9 up 0", 12, 10, 16'h0000, 0);
    step("R9 up rise", 12, 10, 16'h0001, 0);
    step("R9 up steady", 12, 10, 16'h0001, 0);
    step("R9 up fall", 12, 10, 16'h0000, 0);

    // R10: sequence 1,0,0,1 and memory untouched by other ops
    step("R10 down 1", 13, 11, 16'h0001, 0);
    step("R10 down fall", 13, 11, 16'h0000, 0);
    step("R10 down steady", 13, 11, 16'h0000, 0);
    step("R10 down rise", 13, 11, 16'h0001, 0);
    step("R10 other op keeps mem", 6, 11, 16'h0000, 0);
    step("R10 fall after coil", 13, 11, 16'h0000, 0);

    // R11
    step("R11 prime slot", 8, 12, 16'h0001, 0);
    step("R11 prime mem", 12, 12, 16'h0001, 0);
    step("R11 op 14", 14, 12, 16'h0000, 0);
    step("R11 op 15", 15, 12, 16'h0000, 0);
    step("R11 kept out", 9, 12, 16'h0000, 0);
    step("R11 kept mem", 12, 12, 16'h0001, 0);

    // R2: idle holds, back-to-back visibility
    idle("R2 idle hold");
    idle("R2 idle hold again");
    step("R2 b2b write", 6, 13, 16'h0001, 0);
    step("R2 b2b read", 9, 13, 16'h0000, 0);

    // R12
    step("R12 slot 14 set", 8, 14, 16'h0001, 0);
    step("R12 slot 15 untouched", 9, 15, 16'h0000, 0);
    step("R12 slot 14 kept", 9, 14, 16'h0000, 0);
    step("R12 slot 5 kept", 8, 5, 16'h0000, 0);
    step("R12 slot 6 kept", 10, 6, 16'h0000, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule